// File: doc/BRIEF.md
# Flow-Controlled Asynchronous Serial Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single line. Each frame has a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and a stop period. The stop period can be set in sixteenths of a bit. All timing is counted in pulses of a bit-rate enable input. In the normal mode one bit lasts sixteen pulses. In the 1x mode one bit lasts one pulse, and only whole stop bits are available.

A character is taken over a valid/ready handshake. The format fields are captured together with the data, so the caller may change them once the transfer has been accepted. With flow control enabled, the transmitter looks at the active-low clear-to-send input each time it could open a frame. While that input is high, the line stays at the idle (high) level and the character waits. Once a frame has begun, the clear-to-send input no longer matters until the frame is finished. The clear-to-send input passes through a configurable chain of synchronising flops before it is used.

Top module: `uart_cts_tx`

## Requirements
- R1: After a synchronous reset, `tx_ready` is 1 and `txd` is 1.
- R2: A character is accepted only on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the edge after acceptance until the edge that ends the stop period, and it is 1 only while the block is idle.
- R3: A frame is a low start bit, then the data bits least significant bit first. `char_len` selects the data bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8 bits. Unused upper data bits are ignored. In the 16x mode, every start, data and parity bit lasts 16 enable pulses.
- R4: When `par_en` is 1, a parity bit follows the last data bit. With `par_odd` = 0 the parity is even, meaning the data bits plus the parity bit hold an even number of ones. With `par_odd` = 1 the parity is odd.
- R5: In the 16x mode with 6, 7 or 8 data bits, the stop period lasts 9+`stop_sel` pulses when `stop_sel` is 0..7, and 17+`stop_sel` pulses when `stop_sel` is 8..15. That gives 9/16 to 1 bit and 1-9/16 to 2 bits.
- R6: In the 16x mode with 5 data bits, the stop period lasts 17+`stop_sel` pulses, which is 1-1/16 to 2 bits.
- R7: When `one_x_mode` is 1, every bit lasts one enable pulse. The stop period is 1 pulse when `stop_sel`[3] is 0 and 2 pulses when it is 1.
- R8: When `cts_en` is 0, `cts_n` has no effect, and a frame starts at the first enable pulse after acceptance.
- R9: When `cts_en` is 1 and the synchronised `cts_n` is high, a pending character does not start. `txd` stays 1 and `tx_ready` stays 0.
- R10: When `cts_en` is 1, the pending frame starts at the first enable pulse at which the synchronised `cts_n` is low.
- R11: A change on `cts_n` after the start bit has begun does not alter the frame in progress.
- R12: The format fields and `cts_en` are captured at acceptance. Changing them while a frame is pending or in progress does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Bit-rate enable, one clock wide (16 per bit, or 1 per bit in 1x mode) |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Idle and able to accept a character |
| char_len | input | 2 | Data bit count select (00 = 5 ... 11 = 8) |
| par_en | input | 1 | Append parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| stop_sel | input | 4 | Stop period code |
| one_x_mode | input | 1 | 1 = one enable pulse per bit |
| cts_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Active-low clear-to-send |
| txd | output | 1 | Serial output, idle high |

## Verification
A wrong phase in the frame controller shows up on `txd`: a bit has the wrong level at its centre, or the line drops low while the block is held off. The bench catches this within half a bit time of the error. A wrong stop-length decode or timer load moves the edge where `tx_ready` rises back to 1. The bench measures that edge to the exact enable pulse, so an error of one sixteenth of a bit fails at the end of that frame. A captured-format fault or a leaking clear-to-send input changes the bit pattern or the frame count of the next frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_MAX  = 8;
  localparam int BIT_TICKS = 16;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_HOLD  = 3'd1,
    S_START = 3'd2,
    S_DATA  = 3'd3,
    S_PAR   = 3'd4,
    S_STOP  = 3'd5
  } tx_state_t;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic [3:0] stop;
    logic       onex;
    logic       cts_en;
  } tx_cfg_t;

  function automatic logic [DATA_MAX-1:0] len_mask(input logic [1:0] len);
    logic [DATA_MAX-1:0] m;
    for (int i = 0; i < DATA_MAX; i++) m[i] = (i < 5 + int'(len));
    return m;
  endfunction

endpackage

// File: rtl/tx_stop_len.sv
module tx_stop_len #(
  parameter int TW = 5
) (
  input  logic [3:0]    code,
  input  logic          len5,
  input  logic          onex,
  output logic [TW-1:0] stop_m1
);
  // Output is the stop length in enable pulses, minus one.
  always_comb begin
    if (onex)
      stop_m1 = code[3] ? TW'(1) : TW'(0);
    else if (len5 || code[3])
      stop_m1 = TW'(16) + TW'(code);
    else
      stop_m1 = TW'(8) + TW'(code);
  end
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = tick && (cnt == '0);

  // R3: the count only moves on an enable pulse or a load
  p_cnt_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
  import uart_tx_pkg::*;
#(
  parameter int TW = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                cts_ok,
  input  logic                timer_done,
  input  logic [DATA_MAX-1:0] in_data,
  input  logic                in_valid,
  input  tx_cfg_t             in_cfg,
  input  logic [TW-1:0]       stop_m1,
  output logic                in_ready,
  output tx_cfg_t             cfg_q,
  output logic                timer_load,
  output logic [TW-1:0]       timer_val,
  output logic                txd
);
  tx_state_t           st, nxt;
  logic [DATA_MAX-1:0] sh;
  logic [2:0]          idx, idx_d, last_idx;
  logic                par_q, txd_q, txd_d, rdy_q;
  logic                accept, shift;
  logic [TW-1:0]       bit_m1;
  logic [DATA_MAX-1:0] masked;

  assign masked   = in_data & len_mask(in_cfg.len);
  assign last_idx = {1'b0, cfg_q.len} + 3'd4;
  assign bit_m1   = cfg_q.onex ? TW'(0) : TW'(BIT_TICKS - 1);

  always_comb begin
    nxt        = st;
    timer_load = 1'b0;
    timer_val  = bit_m1;
    txd_d      = txd_q;
    shift      = 1'b0;
    idx_d      = idx;
    accept     = 1'b0;
    case (st)
      S_IDLE: if (in_valid && rdy_q) begin
        accept = 1'b1;
        nxt    = S_HOLD;
      end
      S_HOLD: if (tick && (!cfg_q.cts_en || cts_ok)) begin
        nxt        = S_START;
        timer_load = 1'b1;
        txd_d      = 1'b0;
      end
      S_START: if (timer_done) begin
        nxt        = S_DATA;
        timer_load = 1'b1;
        txd_d      = sh[0];
        shift      = 1'b1;
        idx_d      = 3'd0;
      end
      S_DATA: if (timer_done) begin
        timer_load = 1'b1;
        if (idx == last_idx) begin
          if (cfg_q.par_en) begin
            nxt   = S_PAR;
            txd_d = par_q;
          end else begin
            nxt       = S_STOP;
            txd_d     = 1'b1;
            timer_val = stop_m1;
          end
        end else begin
          txd_d = sh[0];
          shift = 1'b1;
          idx_d = idx + 3'd1;
        end
      end
      S_PAR: if (timer_done) begin
        nxt        = S_STOP;
        timer_load = 1'b1;
        timer_val  = stop_m1;
        txd_d      = 1'b1;
      end
      S_STOP: if (timer_done) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      txd_q <= 1'b1;
      rdy_q <= 1'b1;
      sh    <= '0;
      idx   <= '0;
      par_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      st    <= nxt;
      txd_q <= txd_d;
      rdy_q <= (nxt == S_IDLE);
      idx   <= idx_d;
      if (accept) begin
        cfg_q <= in_cfg;
        sh    <= masked;
        par_q <= (^masked) ^ in_cfg.par_odd;
      end else if (shift) begin
        sh <= sh >> 1;
      end
    end
  end

  assign in_ready = rdy_q;
  assign txd      = txd_q;

  // R2: ready is only offered while idle
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> st == S_IDLE);
  // R1: the line is marking whenever idle
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (rst)
    st == S_IDLE |-> txd_q);
  // R9: a held character keeps the line marking
  p_hold_mark_r9: assert property (@(posedge clk) disable iff (rst)
    st == S_HOLD |-> txd_q);
  // R9: negated clear-to-send blocks the start
  p_cts_block_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && cfg_q.cts_en && !cts_ok) |=> st == S_HOLD);
  // R3: start bit is low
  p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
    st == S_START |-> !txd_q);
  // R5: stop period is high
  p_stop_high_r5: assert property (@(posedge clk) disable iff (rst)
    st == S_STOP |-> txd_q);
  // R12: captured format is frozen while busy
  p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    st != S_IDLE |=> $stable(cfg_q));
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_tx_pkg::*;
#(
  parameter int CTS_SYNC_STAGES = 2,
  parameter int CNT_W           = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [3:0] stop_sel,
  input  logic       one_x_mode,
  input  logic       cts_en,
  input  logic       cts_n,
  output logic       txd
);
  tx_cfg_t          in_cfg, cfg_q;
  logic             cts_n_s;
  logic             t_load, t_done;
  logic [CNT_W-1:0] t_val, stop_m1;

  assign in_cfg = '{len: char_len, par_en: par_en, par_odd: par_odd,
                    stop: stop_sel, onex: one_x_mode, cts_en: cts_en};

  generate
    if (CTS_SYNC_STAGES == 0) begin : g_cts_direct
      assign cts_n_s = cts_n;
    end else begin : g_cts_sync
      logic [CTS_SYNC_STAGES-1:0] sync_ff;
      always_ff @(posedge clk) begin
        if (rst) sync_ff <= '1;
        else begin
          sync_ff[0] <= cts_n;
          for (int i = 1; i < CTS_SYNC_STAGES; i++) sync_ff[i] <= sync_ff[i-1];
        end
      end
      assign cts_n_s = sync_ff[CTS_SYNC_STAGES-1];
    end
  endgenerate

  tx_stop_len #(.TW(CNT_W)) u_stop (
    .code    (cfg_q.stop),
    .len5    (cfg_q.len == 2'b00),
    .onex    (cfg_q.onex),
    .stop_m1 (stop_m1)
  );

  tx_bit_timer #(.TW(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick16),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  tx_frame_fsm #(.TW(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick16),
    .cts_ok     (!cts_n_s),
    .timer_done (t_done),
    .in_data    (tx_data),
    .in_valid   (tx_valid),
    .in_cfg     (in_cfg),
    .stop_m1    (stop_m1),
    .in_ready   (tx_ready),
    .cfg_q      (cfg_q),
    .timer_load (t_load),
    .timer_val  (t_val),
    .txd        (txd)
  );
endmodule

// File: tb/tb_uart_cts_tx.sv
module tb_uart_cts_tx;
  logic clk = 0, rst = 1, tick16 = 0;
  logic [7:0] tx_data = 0;
  logic tx_valid = 0, tx_ready, txd;
  logic [1:0] char_len = 2'b11;
  logic par_en = 0, par_odd = 0, one_x_mode = 0, cts_en = 0, cts_n = 0;
  logic [3:0] stop_sel = 4'd7;

  int tests = 0, fails = 0, sent = 0, rx_frames = 0;
  bit mon_busy = 0;

  typedef struct {
    logic [11:0] lv;
    int ncell;
    int endk;
    int bl;
    string req;
  } exp_t;
  exp_t q[$];

  uart_cts_tx dut (.*);

  always #10 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      tick16 = (div == 3);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input string req);
    exp_t e;
    int n, p, st;
    logic par;
    @(negedge clk);
    tx_data = d;
    tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk); #1;
    n = 5 + int'(char_len);
    p = par_en ? 1 : 0;
    par = par_odd;
    for (int i = 0; i < n; i++) par ^= d[i];
    if (one_x_mode) st = stop_sel[3] ? 2 : 1;
    else if (char_len == 2'b00 || stop_sel[3]) st = 17 + int'(stop_sel);
    else st = 9 + int'(stop_sel);
    e.bl = one_x_mode ? 1 : 16;
    e.lv = '0;
    for (int i = 0; i < n; i++) e.lv[1+i] = d[i];
    if (p == 1) e.lv[n+1] = par;
    e.ncell = n + 1 + p;
    e.lv[e.ncell] = 1'b1;
    e.endk = e.bl * (1 + n + p) + st;
    e.req = req;
    q.push_back(e);
    sent++;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (q.size() != 0 || mon_busy || !tx_ready);
    repeat (3) @(negedge clk);
    chk(rx_frames == sent, "R2 frame count", rx_frames, sent);
  endtask

  // monitor: scoreboard against queued frames
  initial begin
    exp_t e;
    bit prev = 1;
    int k = 0, off, c;
    forever begin
      @(posedge clk); #1;
      if (!rst) begin
        if (!mon_busy) begin
          if (prev && !txd) begin
            if (q.size() == 0) chk(0, "R9 unexpected start", 0, 1);
            else begin
              e = q.pop_front();
              mon_busy = 1;
              k = 0;
            end
          end
        end else begin
          off = (e.bl == 16) ? 8 : 0;
          if (tick16) begin
            k++;
            if (k >= off && (k - off) % e.bl == 0) begin
              c = (k - off) / e.bl;
              if (c <= e.ncell)
                chk(txd == e.lv[c], e.req, int'(txd), int'(e.lv[c]));
            end
          end
          if (tx_ready) begin
            chk(k == e.endk, {e.req, " frame length"}, k, e.endk);
            rx_frames++;
            mon_busy = 0;
          end
        end
      end
      prev = txd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit low_seen;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(tx_ready == 1, "R1 ready", int'(tx_ready), 1);
    chk(txd == 1, "R1 txd", int'(txd), 1);

    // R3 8-bit, 1-bit stop (code 7)
    char_len = 2'b11; par_en = 0; stop_sel = 4'd7;
    send(8'hA5, "R3");
    @(negedge clk);
    chk(tx_ready == 0, "R2 busy", int'(tx_ready), 0);
    wait_done();
    // R4 even parity, shortest stop R5
    par_en = 1; par_odd = 0; stop_sel = 4'd0;
    send(8'h3C, "R4 even/R5");
    wait_done();
    // R4 odd parity 7-bit, code 15
    char_len = 2'b10; par_odd = 1; stop_sel = 4'd15;
    send(8'hF1, "R4 odd/R5");
    wait_done();
    // R5 6-bit, code 8
    char_len = 2'b01; par_en = 0; stop_sel = 4'd8;
    send(8'hC9, "R5");
    wait_done();
    // R6 5-bit, code 0 and code 15
    char_len = 2'b00; par_en = 1; par_odd = 0; stop_sel = 4'd0;
    send(8'hEB, "R6");
    wait_done();
    par_en = 0; stop_sel = 4'd15;
    send(8'h13, "R6");
    wait_done();
    // R7 1x mode
    one_x_mode = 1; char_len = 2'b11; stop_sel = 4'd3;
    send(8'h96, "R7");
    wait_done();
    par_en = 1; par_odd = 1; stop_sel = 4'd8;
    send(8'h0F, "R7");
    wait_done();
    one_x_mode = 0; par_en = 0;
    // R8 gating disabled, CTS negated
    cts_en = 0; cts_n = 1; stop_sel = 4'd7;
    send(8'h55, "R8");
    wait_done();
    // R9 / R10 hold then release
    cts_en = 1; cts_n = 1;
    send(8'h81, "R10");
    low_seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!txd) low_seen = 1;
    end
    chk(!low_seen, "R9 line marking", int'(low_seen), 0);
    chk(tx_ready == 0, "R9 ready held", int'(tx_ready), 0);
    chk(rx_frames == sent - 1, "R9 no frame", rx_frames, sent - 1);
    cts_n = 0;
    wait_done();
    // R11 CTS negated mid-frame
    send(8'h7E, "R11");
    do @(negedge clk); while (txd);
    cts_n = 1;
    wait_done();
    cts_n = 0;
    // R12 change format after acceptance
    cts_en = 0; char_len = 2'b11; par_en = 1; par_odd = 0; stop_sel = 4'd7;
    send(8'hD2, "R12");
    char_len = 2'b00; par_en = 0; stop_sel = 4'd0; one_x_mode = 1;
    wait_done();
    one_x_mode = 0;
    // back-to-back
    char_len = 2'b11; par_en = 0; stop_sel = 4'd2;
    send(8'h01, "R2 b2b");
    send(8'hFE, "R2 b2b");
    wait_done();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule